// File: doc/BRIEF.md
# Two-Channel Register Address Decoder with Shared Master Control

This block sits between a byte-wide multiplexed CPU bus and the register file of a two-channel serial controller. For every access it turns the bus address offset into a channel select and a four-bit register index, using one of two address layouts chosen by a two-bit shift-mode field. For reads it also resolves the register aliasing that the controller applies: depending on two per-channel configuration bits (an extended-access enable and an extended-readback bit), some read indices fold onto other status registers, and some return the contents of a write register instead.

The block owns the two pieces of state that both channels share: the master-control register, which a write to index 9 of either channel loads, and the shift-mode field, which a write to index 0 of channel B loads from data bits 1:0. A software device-reset command written to the master-control register clears most of that register but leaves the shift mode untouched. The decode is purely combinational; the shared state changes on the rising clock edge while a write strobe is high.

Top module: `sccdec_top`

## Requirements
- R1: With shift mode 2'b01 (shift-left), the channel select is address bit 0 and the register index is address bits 4:1; channel select 1 means channel A, 0 means channel B.
- R2: With shift mode 2'b10 (shift-right), the channel select is address bit 4 and the register index is address bits 4:1.
- R3: Shift modes 2'b00 and 2'b11 are malformed: a read gives rd_ok_o=0 with chan_o, reg_o and wreg_o all 0, no write strobe rises, and neither the master-control register nor the shift mode changes.
- R4: When the addressed channel's extended-enable bit is 0, read indices 4..7 resolve to 0..3, index 9 to 13, index 11 to 15, every other index to itself, and wreg_o is 0.
- R5: When the addressed channel's extended-enable bit is 1 but its extended-readback bit is 0, reads resolve exactly as in R4.
- R6: When both bits of the addressed channel are 1, read indices 4 and 5 keep their index with wreg_o=1, index 9 resolves to 3, index 11 to 10 and index 14 to 7, each with wreg_o=1; all other indices resolve to themselves with wreg_o=0.
- R7: The configuration bits used for aliasing are taken from the channel the address selects (vector bit 1 for channel A, bit 0 for channel B).
- R8: Writes are never aliased: reg_o carries the raw index and exactly one of wr_a_o or wr_b_o rises, matching the selected channel.
- R9: A write to index 9 from either channel loads the single master-control register with the write data at the next rising clock edge.
- R10: A write to index 9 whose data bits 7:6 are 2'b11 is a device reset: the master-control register becomes the write data masked with 8'h1C (bits 4, 3 and 2 kept) and the shift mode is unchanged.
- R11: A write to index 0 of channel B loads the shift mode from data bits 1:0; the same write on channel A leaves the shift mode unchanged.
- R12: Hardware reset sets the shift mode to 2'b01 and the master-control register to 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shared state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr_i | input | 5 | Bus address offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| ext_en_i | input | 2 | Extended-access enable per channel (bit 1 = A, bit 0 = B) |
| ext_rd_i | input | 2 | Extended-readback select per channel (bit 1 = A, bit 0 = B) |
| chan_o | output | 1 | Selected channel (1 = A, 0 = B) |
| reg_o | output | 4 | Resolved register index |
| wreg_o | output | 1 | Read returns the write register of that index |
| rd_ok_o | output | 1 | Read is well formed |
| wr_a_o | output | 1 | Write strobe for channel A |
| wr_b_o | output | 1 | Write strobe for channel B |
| mode_o | output | 2 | Current shift-mode field |
| mctl_o | output | 8 | Shared master-control register |

## Verification
On every cycle the assertions check that a malformed mode blocks all strobes, that the write channel and raw index follow the address bits of the active layout, that write-register readback only appears when the addressed channel has both configuration bits set, that no base-aliased read ever leaves a folded index, and that the shared registers change only through the commands that own them. The full alias table per index, the choice of the addressed channel's bits rather than the other channel's, the reset values and the recovery from a malformed mode through hardware reset are shown only by the bench's scenarios, which sweep all sixteen indices in each configuration and both layouts.

// File: rtl/sccdec_pkg.sv
package sccdec_pkg;

   // Shift-mode field encodings
   localparam logic [1:0] MODE_LEFT  = 2'b01;
   localparam logic [1:0] MODE_RIGHT = 2'b10;

   // Register indices with a meaning for the shared state
   localparam int unsigned IDX_CMD  = 0;
   localparam int unsigned IDX_MCTL = 9;

   // Device-reset command code in the top two data bits
   localparam logic [1:0] CMD_DEV_RESET = 2'b11;

   // Master-control bits that survive a device-reset command
   localparam logic [7:0] MCTL_KEEP_MASK = 8'h1C;

   typedef struct packed {
      logic       ok;
      logic       chan;
      logic [3:0] idx;
   } raw_dec_t;

endpackage

// File: rtl/sccdec_addr_split.sv
module sccdec_addr_split
   import sccdec_pkg::*;
#(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned REG_W         = 4,
   parameter bit          RIGHT_MODE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        mode_i,
   output logic              ok_o,
   output logic              chan_o,
   output logic [REG_W-1:0]  idx_o
);

   localparam int unsigned CHAN_LO_POS = 0;
   localparam int unsigned CHAN_HI_POS = REG_W;

   logic right_legal;

   generate
      if (RIGHT_MODE_EN) begin : g_right_on
         assign right_legal = 1'b1;
      end else begin : g_right_off
         assign right_legal = 1'b0;
      end
   endgenerate

   always_comb begin
      ok_o   = 1'b0;
      chan_o = 1'b0;
      idx_o  = '0;
      if (mode_i == MODE_LEFT) begin
         ok_o   = 1'b1;
         chan_o = addr_i[CHAN_LO_POS];
         idx_o  = addr_i[REG_W:1];
      end else if ((mode_i == MODE_RIGHT) && right_legal) begin
         ok_o   = 1'b1;
         chan_o = addr_i[CHAN_HI_POS];
         idx_o  = addr_i[REG_W:1];
      end
   end

endmodule

// File: rtl/sccdec_read_alias.sv
module sccdec_read_alias #(
   parameter int unsigned REG_W        = 4,
   parameter bit          EXT_READBACK = 1'b1
) (
   input  logic [REG_W-1:0] idx_i,
   input  logic             ext_en_i,
   input  logic             ext_rd_i,
   output logic [REG_W-1:0] idx_o,
   output logic             wreg_o
);

   localparam logic [REG_W-1:0] I3  = REG_W'(3);
   localparam logic [REG_W-1:0] I4  = REG_W'(4);
   localparam logic [REG_W-1:0] I5  = REG_W'(5);
   localparam logic [REG_W-1:0] I6  = REG_W'(6);
   localparam logic [REG_W-1:0] I7  = REG_W'(7);
   localparam logic [REG_W-1:0] I9  = REG_W'(9);
   localparam logic [REG_W-1:0] I10 = REG_W'(10);
   localparam logic [REG_W-1:0] I11 = REG_W'(11);
   localparam logic [REG_W-1:0] I13 = REG_W'(13);
   localparam logic [REG_W-1:0] I14 = REG_W'(14);
   localparam logic [REG_W-1:0] I15 = REG_W'(15);

   logic ext_on;

   generate
      if (EXT_READBACK) begin : g_ext
         assign ext_on = ext_en_i & ext_rd_i;
      end else begin : g_no_ext
         assign ext_on = 1'b0;
      end
   endgenerate

   always_comb begin
      idx_o  = idx_i;
      wreg_o = 1'b0;
      if (ext_on) begin
         if ((idx_i == I4) || (idx_i == I5)) begin
            wreg_o = 1'b1;
         end else if (idx_i == I9) begin
            idx_o  = I3;
            wreg_o = 1'b1;
         end else if (idx_i == I11) begin
            idx_o  = I10;
            wreg_o = 1'b1;
         end else if (idx_i == I14) begin
            idx_o  = I7;
            wreg_o = 1'b1;
         end
      end else begin
         if ((idx_i == I4) || (idx_i == I5) || (idx_i == I6) || (idx_i == I7)) begin
            idx_o = idx_i & I3;
         end else if (idx_i == I9) begin
            idx_o = I13;
         end else if (idx_i == I11) begin
            idx_o = I15;
         end
      end
   end

endmodule

// File: rtl/sccdec_shared_regs.sv
module sccdec_shared_regs
   import sccdec_pkg::*;
#(
   parameter int unsigned REG_W      = 4,
   parameter int unsigned DATA_W     = 8,
   parameter logic [1:0]  RESET_MODE = MODE_LEFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_any_i,
   input  logic              wr_b_i,
   input  logic [REG_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [1:0]        mode_o,
   output logic [DATA_W-1:0] mctl_o
);

   localparam int unsigned      CMD_HI   = DATA_W - 1;
   localparam int unsigned      CMD_LO   = DATA_W - 2;
   localparam logic [DATA_W-1:0] KEEP    = DATA_W'(MCTL_KEEP_MASK);
   localparam logic [REG_W-1:0] MCTL_IX  = REG_W'(IDX_MCTL);
   localparam logic [REG_W-1:0] CMD_IX   = REG_W'(IDX_CMD);

   logic mctl_hit;
   logic mode_hit;
   logic dev_reset;

   assign mctl_hit  = wr_any_i && (idx_i == MCTL_IX);
   assign mode_hit  = wr_b_i && (idx_i == CMD_IX);
   assign dev_reset = (wdata_i[CMD_HI:CMD_LO] == CMD_DEV_RESET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mctl_o <= '0;
      end else if (mctl_hit) begin
         if (dev_reset) begin
            mctl_o <= wdata_i & KEEP;
         end else begin
            mctl_o <= wdata_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= RESET_MODE;
      end else if (mode_hit) begin
         mode_o <= wdata_i[1:0];
      end
   end

endmodule

// File: rtl/sccdec_top.sv
module sccdec_top
   import sccdec_pkg::*;
#(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned REG_W         = 4,
   parameter int unsigned DATA_W        = 8,
   parameter bit          RIGHT_MODE_EN = 1'b1,
   parameter bit          EXT_READBACK  = 1'b1,
   parameter logic [1:0]  RESET_MODE    = MODE_LEFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [1:0]        ext_en_i,
   input  logic [1:0]        ext_rd_i,
   output logic              chan_o,
   output logic [REG_W-1:0]  reg_o,
   output logic              wreg_o,
   output logic              rd_ok_o,
   output logic              wr_a_o,
   output logic              wr_b_o,
   output logic [1:0]        mode_o,
   output logic [DATA_W-1:0] mctl_o
);

   generate
      if (REG_W != 4) begin : g_bad_reg_w
         $error("sccdec_top: REG_W must be 4");
      end
      if (ADDR_W < REG_W + 1) begin : g_bad_addr_w
         $error("sccdec_top: ADDR_W must cover the register field and bit 0");
      end
      if (DATA_W < 8) begin : g_bad_data_w
         $error("sccdec_top: DATA_W must be at least 8");
      end
   endgenerate

   logic             raw_ok;
   logic             raw_chan;
   logic [REG_W-1:0] raw_idx;
   logic [REG_W-1:0] rd_idx;
   logic             rd_wreg;
   logic             sel_en;
   logic             sel_rd;
   logic             wr_ok;

   sccdec_addr_split #(
      .ADDR_W        (ADDR_W),
      .REG_W         (REG_W),
      .RIGHT_MODE_EN (RIGHT_MODE_EN)
   ) split_i (
      .addr_i (addr_i),
      .mode_i (mode_o),
      .ok_o   (raw_ok),
      .chan_o (raw_chan),
      .idx_o  (raw_idx)
   );

   // Configuration bits of the channel the address selects
   assign sel_en = ext_en_i[raw_chan];
   assign sel_rd = ext_rd_i[raw_chan];

   sccdec_read_alias #(
      .REG_W        (REG_W),
      .EXT_READBACK (EXT_READBACK)
   ) alias_i (
      .idx_i    (raw_idx),
      .ext_en_i (sel_en),
      .ext_rd_i (sel_rd),
      .idx_o    (rd_idx),
      .wreg_o   (rd_wreg)
   );

   assign wr_ok   = raw_ok & wr_i;
   assign wr_a_o  = wr_ok & raw_chan;
   assign wr_b_o  = wr_ok & ~raw_chan;
   assign rd_ok_o = raw_ok & rd_i;
   assign chan_o  = raw_ok & raw_chan;
   assign wreg_o  = rd_ok_o & rd_wreg;
   assign reg_o   = !raw_ok ? '0 : (rd_i ? rd_idx : raw_idx);

   sccdec_shared_regs #(
      .REG_W      (REG_W),
      .DATA_W     (DATA_W),
      .RESET_MODE (RESET_MODE)
   ) shared_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_any_i (wr_ok),
      .wr_b_i   (wr_b_o),
      .idx_i    (raw_idx),
      .wdata_i  (wdata_i),
      .mode_o   (mode_o),
      .mctl_o   (mctl_o)
   );

endmodule

// File: rtl/sccdec_checker.sv
module sccdec_checker #(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned REG_W         = 4,
   parameter int unsigned DATA_W        = 8,
   parameter bit          RIGHT_MODE_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [1:0]        ext_en_i,
   input logic [1:0]        ext_rd_i,
   input logic              chan_o,
   input logic [REG_W-1:0]  reg_o,
   input logic              wreg_o,
   input logic              rd_ok_o,
   input logic              wr_a_o,
   input logic              wr_b_o,
   input logic [1:0]        mode_o,
   input logic [DATA_W-1:0] mctl_o
);

   logic legal;
   logic wr_any;
   logic mctl_wr;
   logic is_reset_cmd;

   assign legal        = (mode_o == 2'b01) || ((mode_o == 2'b10) && RIGHT_MODE_EN);
   assign wr_any       = wr_a_o || wr_b_o;
   assign mctl_wr      = wr_any && (reg_o == REG_W'(9));
   assign is_reset_cmd = (wdata_i[DATA_W-1:DATA_W-2] == 2'b11);

   assert_malformed_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !legal |-> (!rd_ok_o && !wr_a_o && !wr_b_o && !wreg_o));

   assert_left_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && mode_o == 2'b01) |-> (reg_o == addr_i[REG_W:1] && wr_a_o == addr_i[0]));

   assert_right_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && mode_o == 2'b10) |-> (reg_o == addr_i[REG_W:1] && wr_a_o == addr_i[REG_W]));

   assert_one_write_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_a_o, wr_b_o}));

   // R6 and R7: readback only with both bits of the addressed channel set
   assert_wreg_needs_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wreg_o |-> (rd_ok_o && ext_en_i[chan_o] && ext_rd_i[chan_o]));

   // R4 and R5: base aliasing never leaves a folded index
   assert_base_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok_o && !(ext_en_i[chan_o] && ext_rd_i[chan_o])) |->
      (!wreg_o && !(reg_o inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd11})));

   assert_mctl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mctl_wr && !is_reset_cmd) |=> (mctl_o == $past(wdata_i)));

   assert_dev_reset_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mctl_wr && is_reset_cmd) |=>
      (mode_o == $past(mode_o) && mctl_o == ($past(wdata_i) & DATA_W'(8'h1C))));

   assert_mode_only_by_chan_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_b_o && reg_o == '0) |=> $stable(mode_o));

endmodule

bind sccdec_top sccdec_checker #(
   .ADDR_W        (ADDR_W),
   .REG_W         (REG_W),
   .DATA_W        (DATA_W),
   .RIGHT_MODE_EN (RIGHT_MODE_EN)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr_i   (addr_i),
   .wdata_i  (wdata_i),
   .ext_en_i (ext_en_i),
   .ext_rd_i (ext_rd_i),
   .chan_o   (chan_o),
   .reg_o    (reg_o),
   .wreg_o   (wreg_o),
   .rd_ok_o  (rd_ok_o),
   .wr_a_o   (wr_a_o),
   .wr_b_o   (wr_b_o),
   .mode_o   (mode_o),
   .mctl_o   (mctl_o)
);

// File: tb/sccdec_tb.sv
module sccdec_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] addr_i = '0;
   logic       rd_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic [1:0] ext_en_i = '0;
   logic [1:0] ext_rd_i = '0;
   logic       chan_o;
   logic [3:0] reg_o;
   logic       wreg_o;
   logic       rd_ok_o;
   logic       wr_a_o;
   logic       wr_b_o;
   logic [1:0] mode_o;
   logic [7:0] mctl_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sccdec_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (addr_i),
      .rd_i     (rd_i),
      .wr_i     (wr_i),
      .wdata_i  (wdata_i),
      .ext_en_i (ext_en_i),
      .ext_rd_i (ext_rd_i),
      .chan_o   (chan_o),
      .reg_o    (reg_o),
      .wreg_o   (wreg_o),
      .rd_ok_o  (rd_ok_o),
      .wr_a_o   (wr_a_o),
      .wr_b_o   (wr_b_o),
      .mode_o   (mode_o),
      .mctl_o   (mctl_o)
   );

   typedef struct {
      bit    is_state;
      bit    ok;
      bit    ch;
      int    idx;
      bit    w;
      bit    wa;
      bit    wb;
      int    mode;
      int    mctl;
      string req;
   } item_t;

   item_t sb_q[$];

   // Expected read resolution, written from R4..R6
   function automatic void exp_read(input int idx, input bit en, input bit rb,
                                    output int ridx, output bit w);
      ridx = idx;
      w    = 1'b0;
      if (en && rb) begin
         case (idx)
            4, 5: w = 1'b1;
            9:  begin ridx = 3;  w = 1'b1; end
            11: begin ridx = 10; w = 1'b1; end
            14: begin ridx = 7;  w = 1'b1; end
            default: ;
         endcase
      end else begin
         if (idx >= 4 && idx <= 7) ridx = idx - 4;
         else if (idx == 9) ridx = 13;
         else if (idx == 11) ridx = 15;
      end
   endfunction

   task automatic access(input bit rd, input bit wr, input logic [4:0] a,
                         input logic [7:0] d, input item_t e);
      @(negedge clk);
      rd_i = rd; wr_i = wr; addr_i = a; wdata_i = d;
      sb_q.push_back(e);
   endtask

   task automatic rd_left(input int ch, input int idx, input string req);
      item_t e;
      int    r;
      bit    w;
      exp_read(idx, ext_en_i[ch], ext_rd_i[ch], r, w);
      e = '{0, 1, ch[0], r, w, 0, 0, 0, 0, req};
      access(1'b1, 1'b0, {idx[3:0], ch[0]}, 8'h00, e);
   endtask

   task automatic rd_right(input int idx, input string req);
      item_t e;
      int    r;
      bit    w;
      bit    ch;
      ch = idx[3];
      exp_read(idx, ext_en_i[ch], ext_rd_i[ch], r, w);
      e = '{0, 1, ch, r, w, 0, 0, 0, 0, req};
      access(1'b1, 1'b0, {idx[3:0], 1'b0}, 8'h00, e);
   endtask

   task automatic wr_acc(input logic [4:0] a, input logic [7:0] d, input bit ok,
                         input bit ch, input int idx, input string req);
      item_t e;
      e = '{0, ok, ok & ch, ok ? idx : 0, 0, ok & ch, ok & ~ch, 0, 0, req};
      access(1'b0, 1'b1, a, d, e);
   endtask

   task automatic rd_bad(input logic [4:0] a, input string req);
      item_t e;
      e = '{0, 0, 0, 0, 0, 0, 0, 0, 0, req};
      access(1'b1, 1'b0, a, 8'h00, e);
   endtask

   task automatic chk_state(input int mode, input int mctl, input string req);
      item_t e;
      e = '{1, 0, 0, 0, 0, 0, 0, mode, mctl, req};
      access(1'b0, 1'b0, 5'd0, 8'h00, e);
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rd_i = 1'b0; wr_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: compares outputs 2 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            checks++;
            if (e.is_state) begin
               if (int'(mode_o) != e.mode || int'(mctl_o) != e.mctl) begin
                  failures++;
                  $display("FAIL %s: mode=%0d mctl=%02h expected mode=%0d mctl=%02h",
                           e.req, mode_o, mctl_o, e.mode, e.mctl);
               end
            end else begin
               if (rd_ok_o != (e.ok & rd_i) || chan_o != e.ch || int'(reg_o) != e.idx ||
                   wreg_o != e.w || wr_a_o != e.wa || wr_b_o != e.wb) begin
                  failures++;
                  $display("FAIL %s: addr=%02h ok=%0b ch=%0b reg=%0d w=%0b wa=%0b wb=%0b expected ok=%0b ch=%0b reg=%0d w=%0b wa=%0b wb=%0b",
                           e.req, addr_i, rd_ok_o, chan_o, reg_o, wreg_o, wr_a_o, wr_b_o,
                           e.ok & rd_i, e.ch, e.idx, e.w, e.wa, e.wb);
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_state(1, 8'h00, "R12 reset state");

      // R1 / R4: shift-left, base aliasing
      ext_en_i = 2'b00; ext_rd_i = 2'b00;
      for (int ch = 0; ch < 2; ch++)
         for (int idx = 0; idx < 16; idx++) rd_left(ch, idx, "R4 base alias");
      rd_left(1, 12, "R1 left layout");

      // R5: enable set, readback clear
      ext_en_i = 2'b11; ext_rd_i = 2'b00;
      for (int ch = 0; ch < 2; ch++)
         for (int idx = 0; idx < 16; idx++) rd_left(ch, idx, "R5 enable only");

      // R6: both set
      ext_en_i = 2'b11; ext_rd_i = 2'b11;
      for (int ch = 0; ch < 2; ch++)
         for (int idx = 0; idx < 16; idx++) rd_left(ch, idx, "R6 readback");

      // R7: only channel A configured
      ext_en_i = 2'b10; ext_rd_i = 2'b10;
      rd_left(0, 9, "R7 chan B bits");
      rd_left(1, 9, "R7 chan A bits");
      rd_left(0, 4, "R7 chan B bits");
      rd_left(1, 14, "R7 chan A bits");

      // R8: writes are not aliased
      wr_acc({4'd5, 1'b1}, 8'h00, 1, 1, 5, "R8 write A raw");
      wr_acc({4'd11, 1'b0}, 8'h00, 1, 0, 11, "R8 write B raw");
      chk_state(1, 8'h00, "R8 no side effect");

      // R9: shared master control from both channels
      wr_acc({4'd9, 1'b0}, 8'h2A, 1, 0, 9, "R9 write from B");
      chk_state(1, 8'h2A, "R9 loaded from B");
      wr_acc({4'd9, 1'b1}, 8'h15, 1, 1, 9, "R9 write from A");
      chk_state(1, 8'h15, "R9 loaded from A");

      // R11: mode only from channel B
      wr_acc({4'd0, 1'b1}, 8'h02, 1, 1, 0, "R11 write A idx0");
      chk_state(1, 8'h15, "R11 A does not set mode");
      wr_acc({4'd0, 1'b0}, 8'h02, 1, 0, 0, "R11 write B idx0");
      chk_state(2, 8'h15, "R11 B sets right mode");

      // R2: shift-right layout
      ext_en_i = 2'b00; ext_rd_i = 2'b00;
      for (int idx = 0; idx < 16; idx++) rd_right(idx, "R2 right layout");
      ext_en_i = 2'b11; ext_rd_i = 2'b11;
      for (int idx = 0; idx < 16; idx++) rd_right(idx, "R2 right readback");
      wr_acc(5'b10010, 8'h03, 1, 1, 9, "R2 right write");
      chk_state(2, 8'h03, "R9 right mode load");

      // R10: device reset keeps mode
      wr_acc(5'b10010, 8'hFF, 1, 1, 9, "R10 device reset");
      chk_state(2, 8'h1C, "R10 mode kept, mask applied");

      // R3: malformed mode 11
      wr_acc(5'b00000, 8'h03, 1, 0, 0, "R11 set mode 11");
      chk_state(3, 8'h1C, "R11 mode 11 stored");
      rd_bad(5'b10011, "R3 read malformed");
      rd_bad(5'b01011, "R3 read malformed");
      wr_acc(5'b10010, 8'h55, 0, 0, 0, "R3 write ignored");
      wr_acc(5'b00000, 8'h01, 0, 0, 0, "R3 mode write ignored");
      chk_state(3, 8'h1C, "R3 state untouched");

      // R12: hardware reset recovers
      hw_reset();
      chk_state(1, 8'h00, "R12 after hw reset");

      // R3: malformed mode 00
      wr_acc(5'b00000, 8'h00, 1, 0, 0, "R11 set mode 00");
      chk_state(0, 8'h00, "R11 mode 00 stored");
      rd_bad(5'b00101, "R3 read mode 00");
      wr_acc(5'b10010, 8'h77, 0, 0, 0, "R3 write mode 00 ignored");
      chk_state(0, 8'h00, "R3 state untouched mode 00");
      hw_reset();
      chk_state(1, 8'h00, "R12 second hw reset");

      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule